// File: doc/BRIEF.md
# Partitioned Subword Arithmetic Unit

This unit treats each of its two 64-bit operands as four independent 16-bit lanes and applies one operation to every lane pair at the same time. The operations are:

- add and subtract, each in three overflow modes;
- scaled add, where the first operand is shifted left or right before the second is added;
- a rounding average;
- lane-local shifts left and right.

No carry, borrow or shifted bit ever moves from one lane into its neighbour.

The block sits in an execution pipeline as a single register stage. Opcode, overflow mode, shift amount and both operands are presented together. The packed result appears on the output one clock later. The scaled-add forms let software multiply packed pixels by small integer or fractional constants without a multiplier. The average is free of overflow and suits interpolation.

Top module: `packed_lane_alu`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it is released, result_o is all zeros.
- R2: Every lane i (bits 16i+15..16i) of result_o depends only on lane i of a_i and b_i, for every opcode.
- R3: Opcode 0 (add) sums the lanes. In mode 0 or 3 the sum is taken modulo 2^16. In mode 1 the sum is treated as signed and clamps to 0x7FFF or 0x8000. In mode 2 the sum is treated as unsigned and clamps to 0xFFFF.
- R4: Opcode 1 (subtract) computes a minus b per lane. In mode 0 or 3 the difference is taken modulo 2^16. In mode 1 it clamps to the signed limits 0x7FFF and 0x8000. In mode 2 any negative difference becomes 0x0000.
- R5: Opcode 2 computes, per lane, the signed a shifted left by shamt_i[1:0], plus the signed b, and clamps the result to the signed 16-bit range.
- R6: Opcode 3 computes, per lane, the signed a shifted arithmetically right by shamt_i[1:0] (rounding toward minus infinity), plus the signed b, and clamps the result to the signed 16-bit range.
- R7: Opcode 4 gives (a+b+1)>>1 per lane on unsigned values with a 17-bit sum, so the result is never clamped.
- R8: Opcode 5 shifts each lane of a right by shamt_i (0 to 15) and fills with copies of the lane's sign bit.
- R9: Opcode 6 shifts each lane of a right by shamt_i (0 to 15) and fills with zeros.
- R10: Opcode 7 shifts each lane of a left by shamt_i (0 to 15) and fills with zeros.
- R11: Opcodes 8 to 15 give an all-zero result.
- R12: mode_i has no effect on any opcode other than 0 and 1. shamt_i[3:2] has no effect on opcodes 2 and 3. A result is visible on result_o exactly one clock after its inputs are sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| op_i | input | 4 | Operation select |
| mode_i | input | 2 | Overflow mode for add and subtract |
| shamt_i | input | 4 | Shift amount |
| a_i | input | 64 | First packed operand |
| b_i | input | 64 | Second packed operand |
| result_o | output | 64 | Registered packed result |

## Verification
On every cycle the assertions check the following properties:

- the reset value;
- that an unused opcode yields zero;
- that an unsigned saturating add never drops below its first operand;
- that each average lane lies between its two inputs;
- that a zero-distance lane shift returns the operand unchanged.

Exact arithmetic results for each lane can only be shown by the bench. It compares every opcode, mode and shift amount against an integer model over all pairings of signed and unsigned boundary values, and adds random operands. Lane isolation and the lack of effect from the mode and the upper shift bits are demonstrated by those sweeps.

// File: rtl/lane_alu_pkg.sv
package lane_alu_pkg;
  localparam logic [3:0] OP_ADD    = 4'd0;
  localparam logic [3:0] OP_SUB    = 4'd1;
  localparam logic [3:0] OP_SHLADD = 4'd2;
  localparam logic [3:0] OP_SHRADD = 4'd3;
  localparam logic [3:0] OP_AVG    = 4'd4;
  localparam logic [3:0] OP_SHR_S  = 4'd5;
  localparam logic [3:0] OP_SHR_U  = 4'd6;
  localparam logic [3:0] OP_SHL    = 4'd7;

  localparam logic [1:0] MD_WRAP = 2'd0;
  localparam logic [1:0] MD_SSAT = 2'd1;
  localparam logic [1:0] MD_USAT = 2'd2;
endpackage

// File: rtl/lane_arith.sv
module lane_arith
  import lane_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [3:0]   op_i,
  input  logic [1:0]   mode_i,
  input  logic [1:0]   k_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] y_o
);
  localparam int XW = W + 4;
  localparam logic signed [XW-1:0] SMAX = XW'((1 << (W-1)) - 1);
  localparam logic signed [XW-1:0] SMIN = -SMAX - XW'(1);

  function automatic logic [W-1:0] clamp_s(input logic signed [XW-1:0] v);
    if (v > SMAX)      return SMAX[W-1:0];
    else if (v < SMIN) return SMIN[W-1:0];
    else               return v[W-1:0];
  endfunction

  logic signed [XW-1:0] a_s, b_s, s_add, s_sub, sc_l, sc_r, s_scl, s_scr;
  logic        [W:0]    u_add, u_sub, u_avg;

  always_comb begin
    a_s   = {{4{a_i[W-1]}}, a_i};
    b_s   = {{4{b_i[W-1]}}, b_i};
    s_add = a_s + b_s;
    s_sub = a_s - b_s;
    sc_l  = a_s <<< k_i;
    sc_r  = a_s >>> k_i;
    s_scl = sc_l + b_s;
    s_scr = sc_r + b_s;
    u_add = {1'b0, a_i} + {1'b0, b_i};
    u_sub = {1'b0, a_i} - {1'b0, b_i};
    u_avg = u_add + (W+1)'(1);
  end

  always_comb begin
    y_o = '0;
    unique case (op_i)
      OP_ADD: begin
        if (mode_i == MD_SSAT)      y_o = clamp_s(s_add);
        else if (mode_i == MD_USAT) y_o = u_add[W] ? '1 : u_add[W-1:0];
        else                        y_o = u_add[W-1:0];
      end
      OP_SUB: begin
        if (mode_i == MD_SSAT)      y_o = clamp_s(s_sub);
        else if (mode_i == MD_USAT) y_o = u_sub[W] ? '0 : u_sub[W-1:0];
        else                        y_o = u_sub[W-1:0];
      end
      OP_SHLADD: y_o = clamp_s(s_scl);
      OP_SHRADD: y_o = clamp_s(s_scr);
      OP_AVG:    y_o = u_avg[W:1]; // sum carry lands in MSB
      default:   y_o = '0;
    endcase
  end
endmodule

// File: rtl/lane_shift.sv
module lane_shift
  import lane_alu_pkg::*;
#(
  parameter int W   = 16,
  parameter int SHW = $clog2(W)
) (
  input  logic [3:0]     op_i,
  input  logic [SHW-1:0] sh_i,
  input  logic [W-1:0]   a_i,
  output logic [W-1:0]   y_o
);
  always_comb begin
    unique case (op_i)
      OP_SHR_S: y_o = W'($signed(a_i) >>> sh_i);
      OP_SHR_U: y_o = a_i >> sh_i;
      OP_SHL:   y_o = a_i << sh_i;
      default:  y_o = '0;
    endcase
  end
endmodule

// File: rtl/lane_unit.sv
module lane_unit
  import lane_alu_pkg::*;
#(
  parameter int W   = 16,
  parameter int SHW = $clog2(W)
) (
  input  logic [3:0]     op_i,
  input  logic [1:0]     mode_i,
  input  logic [SHW-1:0] shamt_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic [W-1:0]   y_o
);
  logic [W-1:0] arith_y, shift_y;
  logic         is_arith, is_shift;

  lane_arith #(.W(W)) u_arith (
    .op_i  (op_i),
    .mode_i(mode_i),
    .k_i   (shamt_i[1:0]),
    .a_i   (a_i),
    .b_i   (b_i),
    .y_o   (arith_y)
  );

  lane_shift #(.W(W), .SHW(SHW)) u_shift (
    .op_i(op_i),
    .sh_i(shamt_i),
    .a_i (a_i),
    .y_o (shift_y)
  );

  always_comb begin
    is_arith = (op_i <= OP_AVG);
    is_shift = (op_i >= OP_SHR_S) && (op_i <= OP_SHL);
    if (is_arith)      y_o = arith_y;
    else if (is_shift) y_o = shift_y;
    else               y_o = '0;
  end
endmodule

// File: rtl/packed_lane_alu.sv
module packed_lane_alu #(
  parameter  int LANES  = 4,
  parameter  int LANE_W = 16,
  localparam int DW     = LANES * LANE_W,
  localparam int SHW    = $clog2(LANE_W)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [3:0]     op_i,
  input  logic [1:0]     mode_i,
  input  logic [SHW-1:0] shamt_i,
  input  logic [DW-1:0]  a_i,
  input  logic [DW-1:0]  b_i,
  output logic [DW-1:0]  result_o
);
  logic [DW-1:0] result_d;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    lane_unit #(.W(LANE_W), .SHW(SHW)) u_lane (
      .op_i   (op_i),
      .mode_i (mode_i),
      .shamt_i(shamt_i),
      .a_i    (a_i[l*LANE_W +: LANE_W]),
      .b_i    (b_i[l*LANE_W +: LANE_W]),
      .y_o    (result_d[l*LANE_W +: LANE_W])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) result_o <= '0;
    else         result_o <= result_d;
  end
endmodule

// File: rtl/packed_lane_alu_chk.sv
module packed_lane_alu_chk #(
  parameter int LANES  = 4,
  parameter int LANE_W = 16,
  parameter int DW     = LANES * LANE_W,
  parameter int SHW    = $clog2(LANE_W)
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic [3:0]     op_i,
  input logic [1:0]     mode_i,
  input logic [SHW-1:0] shamt_i,
  input logic [DW-1:0]  a_i,
  input logic [DW-1:0]  b_i,
  input logic [DW-1:0]  result_o
);
  // R1
  reset_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> result_o == '0);

  // R11
  unused_op_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i[3] |=> result_o == '0);

  for (genvar l = 0; l < LANES; l++) begin : g_lchk
    // R3
    usat_floor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_i == 4'd0 && mode_i == 2'd2)
      |=> result_o[l*LANE_W +: LANE_W] >= $past(a_i[l*LANE_W +: LANE_W]));

    // R7
    avg_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_i == 4'd4)
      |=> (result_o[l*LANE_W +: LANE_W] >= $past(a_i[l*LANE_W +: LANE_W]) ||
           result_o[l*LANE_W +: LANE_W] >= $past(b_i[l*LANE_W +: LANE_W])) &&
          (result_o[l*LANE_W +: LANE_W] <= $past(a_i[l*LANE_W +: LANE_W]) ||
           result_o[l*LANE_W +: LANE_W] <= $past(b_i[l*LANE_W +: LANE_W])));
  end

  // R8 R9 R10
  zero_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i >= 4'd5 && op_i <= 4'd7 && shamt_i == '0) |=> result_o == $past(a_i));
endmodule

bind packed_lane_alu packed_lane_alu_chk #(.LANES(LANES), .LANE_W(LANE_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op_i), .mode_i(mode_i),
  .shamt_i(shamt_i), .a_i(a_i), .b_i(b_i), .result_o(result_o)
);

// File: tb/sim_packed_lane_alu.sv
`timescale 1ns/1ps
module sim_packed_lane_alu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  op = '0;
  logic [1:0]  mode = '0;
  logic [3:0]  shamt = '0;
  logic [63:0] a = '0, b = '0;
  logic [63:0] res;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  packed_lane_alu u0 (
    .clk_i(clk), .rst_ni(rst_n), .op_i(op), .mode_i(mode),
    .shamt_i(shamt), .a_i(a), .b_i(b), .result_o(res)
  );

  logic [15:0] bnd [8] = '{16'h0000, 16'h0001, 16'h7FFE, 16'h7FFF,
                           16'h8000, 16'h8001, 16'hFFFE, 16'hFFFF};

  function automatic int sx(input logic [15:0] v);
    return v[15] ? int'(v) - 65536 : int'(v);
  endfunction

  function automatic logic [15:0] sclip(input int v);
    if (v > 32767)  return 16'h7FFF;
    if (v < -32768) return 16'h8000;
    return 16'(v);
  endfunction

  function automatic logic [15:0] model(input logic [3:0] o, input logic [1:0] m,
                                        input logic [3:0] s, input logic [15:0] x,
                                        input logic [15:0] y);
    int ux = int'(x), uy = int'(y), k = int'(s[1:0]);
    case (o)
      4'd0: begin
        if (m == 2'd1) return sclip(sx(x) + sx(y));
        if (m == 2'd2) return (ux + uy > 65535) ? 16'hFFFF : 16'(ux + uy);
        return 16'(ux + uy);
      end
      4'd1: begin
        if (m == 2'd1) return sclip(sx(x) - sx(y));
        if (m == 2'd2) return (ux < uy) ? 16'h0000 : 16'(ux - uy);
        return 16'(ux - uy);
      end
      4'd2: return sclip(sx(x) * (1 << k) + sx(y));
      4'd3: return sclip((sx(x) >>> k) + sx(y));
      4'd4: return 16'((ux + uy + 1) / 2);
      4'd5: return 16'(sx(x) >>> int'(s));
      4'd6: return 16'(ux >> int'(s));
      4'd7: return 16'(ux << int'(s));
      default: return 16'h0000;
    endcase
  endfunction

  function automatic string tag(input logic [3:0] o);
    case (o)
      4'd0: return "R3";
      4'd1: return "R4";
      4'd2: return "R5";
      4'd3: return "R6";
      4'd4: return "R7";
      4'd5: return "R8";
      4'd6: return "R9";
      4'd7: return "R10";
      default: return "R11";
    endcase
  endfunction

  // R2 R12: every lane checked in isolation one cycle after the inputs
  task automatic run(input logic [3:0] o, input logic [1:0] m, input logic [3:0] s,
                     input logic [63:0] x, input logic [63:0] y);
    logic [63:0] exp;
    @(negedge clk);
    op = o; mode = m; shamt = s; a = x; b = y;
    for (int l = 0; l < 4; l++)
      exp[l*16 +: 16] = model(o, m, s, x[l*16 +: 16], y[l*16 +: 16]);
    @(negedge clk);
    checks++;
    if (res !== exp) begin
      errors++;
      $display("FAIL %s op=%0d mode=%0d sh=%0d a=%h b=%h actual=%h expected=%h",
               tag(o), o, m, s, x, y, res, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (res !== 64'h0) begin
      errors++;
      $display("FAIL R1 reset actual=%h expected=%h", res, 64'h0);
    end
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (res !== 64'h0) begin
      errors++;
      $display("FAIL R1 post-release actual=%h expected=%h", res, 64'h0);
    end
    for (int o = 0; o < 16; o++)
      for (int m = 0; m < 4; m++)
        for (int s = 0; s < 16; s++) begin
          if ((o == 0 || o == 1 || o == 4 || o > 7) && s != 0) continue;
          if ((o == 2 || o == 3) && s > 7) continue; // s 4..7 exercise R12 upper bits
          for (int i = 0; i < 8; i++)
            for (int j = 0; j < 8; j++) begin
              logic [63:0] x, y;
              for (int l = 0; l < 4; l++) begin
                x[l*16 +: 16] = bnd[(i + l) % 8];
                y[l*16 +: 16] = bnd[(j + 3*l) % 8];
              end
              run(4'(o), 2'(m), 4'(s), x, y);
            end
        end
    // R2: random operands, independent lanes
    for (int n = 0; n < 2000; n++)
      run(4'($urandom_range(0, 9)), 2'($urandom), 4'($urandom),
          {$urandom, $urandom}, {$urandom, $urandom});
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule